// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers twelve interrupt request lines into sticky pending latches and hands a small CPU core the program-memory address of the handler it should enter next. Each source has its own enable bit, and a global enable gates the whole selection. The core pulses `last_cycle` during the final clock of every instruction. At that rising edge the controller looks at the latched, enabled requests and, when the global enable is set, picks the one with the lowest index. It then presents that source's vector address until the core acknowledges it.

The vector table starts with the reset entry at address 0x0000, so source index `k` (0..11) lands at address `2*(k+1)`. The first source is at 0x0002 and the last at 0x0018. Index order is also priority order: the bus-reset source comes first, then the two timer ticks, then five endpoint sources, then hub, DAC, GPIO and serial-bus sources. Taking an interrupt clears the global enable, so nesting happens only when firmware re-arms it. The core's forced CALL and the JMP through the table come after this block and are not part of it. They add the latency: cycles left in the current instruction, plus 10, plus 5.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset, `vec_valid` is 0 and `vec_addr` is 0x0000. All pending latches, all per-source enables and the global enable are cleared.
- R2: A high `irq_req[k]` on any clock edge sets pending latch `k`. The latch stays set after the request drops, until that source is acknowledged.
- R3: A vector is taken only at a rising edge where `last_cycle` is 1, the global enable is 1, no vector is outstanding, and at least one pending source is enabled. `vec_valid` goes high right after that edge. Latches set on that same edge are not considered until the next `last_cycle`.
- R4: When several enabled sources are pending, the lowest index wins. `vec_addr` equals `2*(k+1)`: source 0 gives 0x0002 and source 11 gives 0x0018.
- R5: A source whose enable bit is 0 still latches its request but is never selected. Once `en_we` writes `en_wdata` with bit `k` set, the held request becomes eligible.
- R6: While the global enable is 0, nothing is taken. Taking a vector clears the global enable. A `gie_we` write of `gie_wdata` sets it again. If the write falls on the same edge as a take, the take wins.
- R7: `vec_ack` while `vec_valid` is 1 clears the presented source's latch and drops `vec_valid` on the next edge. A new request for that source on the same edge leaves the latch set. Other pending latches are untouched.
- R8: While `vec_valid` is 1 and no acknowledge arrives, `vec_addr` stays constant and no new selection happens, even on further `last_cycle` edges.
- R9: `vec_ack` while `vec_valid` is 0 has no effect on any latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 12 | Request lines, index 0 has highest priority |
| en_we | input | 1 | Write strobe for the per-source enable register |
| en_wdata | input | 12 | New per-source enable bits |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| last_cycle | input | 1 | High during the final clock of the current instruction |
| vec_ack | input | 1 | Core has taken the presented vector |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | 16 | Handler address, 2*(index+1) |

## Verification
The bench aims at simultaneous requests with different priorities, requests held back by a cleared enable bit, and an acknowledge that coincides with a fresh request from the same source. A wrong design would serve the higher index first, would lose a held request, or would drop the re-raised request. It also checks that the global enable falls when a vector is taken. A design that left it set would chain vectors without firmware consent. It checks that extra `last_cycle` pulses during an outstanding vector leave the address alone. It checks that a stray acknowledge with no vector outstanding erases no pending request.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
    localparam int unsigned DFLT_NUM_SRC = 12;
    localparam int unsigned DFLT_ADDR_W  = 16;

    // Table slot 0 is the reset entry; source k sits one slot higher.
    function automatic logic [31:0] slot_addr(input logic [31:0] src_idx);
        return (src_idx + 32'd1) << 1;
    endfunction
endpackage

// File: rtl/intvec_pend.sv
module intvec_pend #(
    parameter int unsigned NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] pend_d, pend_q;

    // One sticky cell per source; a set in the clear cycle wins.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        always_comb begin
            pend_d[g] = (pend_q[g] & ~clr_i[g]) | set_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R7: a clear without a simultaneous set leaves the bit empty
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
    parameter int unsigned NUM_SRC = 12,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        // Scan downward so the lowest set index is written last.
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
    parameter int unsigned NUM_SRC = intvec_pkg::DFLT_NUM_SRC,
    parameter int unsigned ADDR_W  = intvec_pkg::DFLT_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               gie_we,
    input  logic               gie_wdata,
    input  logic               last_cycle,
    input  logic               vec_ack,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               gie;
        logic               valid;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  addr;
    } ctl_t;

    ctl_t               s_d, s_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr_vec;
    logic               any_sel;
    logic [IDX_W-1:0]   sel_idx;
    logic               take;
    logic               ack_ok;

    intvec_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_req),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    intvec_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .req_i (pend & s_q.en),
        .any_o (any_sel),
        .idx_o (sel_idx)
    );

    always_comb begin
        ack_ok  = vec_ack && s_q.valid;
        take    = last_cycle && s_q.gie && !s_q.valid && any_sel;
        clr_vec = ack_ok ? (NUM_SRC'(1) << s_q.idx) : '0;

        s_d = s_q;
        if (en_we)  s_d.en  = en_wdata;
        if (gie_we) s_d.gie = gie_wdata;
        if (ack_ok) s_d.valid = 1'b0;
        if (take) begin
            s_d.valid = 1'b1;
            s_d.idx   = sel_idx;
            s_d.addr  = ADDR_W'(intvec_pkg::slot_addr(32'(sel_idx)));
            s_d.gie   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vec_valid = s_q.valid;
    assign vec_addr  = s_q.addr;

    // R8: an unacknowledged vector holds its address
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_addr)));

    // R7: acknowledge retires the vector
    a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ack) |=> !vec_valid);

    // R3: a vector appears only after an instruction-end edge
    a_r3_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(last_cycle));

    // R6: taking a vector leaves the global enable cleared
    a_r6_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> (!s_q.gie && $past(s_q.gie)));

    // R4: presented address lies inside the source part of the table
    a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (!vec_addr[0] && vec_addr >= ADDR_W'(2)
                       && vec_addr <= ADDR_W'(2 * NUM_SRC)));
endmodule

// File: tb/intvec_ctrl_tb.sv
module intvec_ctrl_tb_top;
    localparam int N = 12;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          en_we = 1'b0;
    logic [N-1:0]  en_wdata = '0;
    logic          gie_we = 1'b0;
    logic          gie_wdata = 1'b0;
    logic          last_cycle = 1'b0;
    logic          vec_ack = 1'b0;
    logic          vec_valid;
    logic [AW-1:0] vec_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    intvec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .en_we(en_we), .en_wdata(en_wdata),
        .gie_we(gie_we), .gie_wdata(gie_wdata),
        .last_cycle(last_cycle), .vec_ack(vec_ack),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    // Reference state, built from the requirements
    logic [N-1:0]  m_pend, m_en;
    logic          m_gie, m_valid;
    int            m_idx;
    logic [AW-1:0] m_addr;

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_gie = 1'b0; m_valid = 1'b0;
            m_idx = 0; m_addr = '0;
        end else begin
            automatic logic [N-1:0] clr = '0;
            automatic int w = lowest(m_pend & m_en);
            automatic bit tk = last_cycle && m_gie && !m_valid && (w >= 0);
            if (vec_ack && m_valid) begin
                clr[m_idx] = 1'b1;
                m_valid = 1'b0;
            end
            m_pend = (m_pend & ~clr) | irq_req;
            if (en_we) m_en = en_wdata;
            if (gie_we) m_gie = gie_wdata;
            if (tk) begin
                m_valid = 1'b1; m_idx = w;
                m_addr = AW'(2 * (w + 1)); m_gie = 1'b0;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Continuous comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3", vec_valid, m_valid);
            if (m_valid) check("R4", vec_addr, m_addr);
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        irq_req = '0; en_we = 0; gie_we = 0; last_cycle = 0; vec_ack = 0;
    endtask

    task automatic arm();
        gie_we = 1; gie_wdata = 1; cyc(); idle();
    endtask

    task automatic strobe();
        last_cycle = 1; cyc(); idle();
    endtask

    task automatic ack();
        vec_ack = 1; cyc(); idle();
    endtask

    initial begin
        void'($urandom(32'd2718));
        cyc(3);
        check("R1", vec_valid, 0);
        check("R1", vec_addr, 0);
        rst_n = 1; cyc();
        // R1: enables cleared by reset, so a request plus strobe yields nothing
        gie_we = 1; gie_wdata = 1; irq_req = 12'h001; cyc(); idle();
        strobe();
        check("R1", vec_valid, 0);
        en_we = 1; en_wdata = '1; cyc(); idle();
        // R2: the earlier pulse is still latched; R4: source 0 -> 0x0002
        strobe();
        check("R2", vec_valid, 1);
        check("R4", vec_addr, 16'h0002);
        ack();
        // R4: priority between sources 5 and 2
        arm();
        irq_req = 12'h024; cyc(); idle();
        strobe();
        check("R4", vec_addr, 16'h0006);
        // R8: more strobes while held change nothing
        strobe(); strobe();
        check("R8", vec_addr, 16'h0006);
        check("R8", vec_valid, 1);
        ack();
        // R6: global enable was cleared by the take
        strobe();
        check("R6", vec_valid, 0);
        arm(); strobe();
        check("R6", vec_addr, 16'h000C);
        ack();
        // R5: a masked source latches but waits
        en_we = 1; en_wdata = 12'h7FF; irq_req = 12'h800; cyc(); idle();
        arm(); strobe();
        check("R5", vec_valid, 0);
        en_we = 1; en_wdata = '1; cyc(); idle();
        strobe();
        check("R5", vec_addr, 16'h0018);
        // R7: ack with the same source re-requesting keeps it pending
        vec_ack = 1; irq_req = 12'h800; cyc(); idle();
        check("R7", vec_valid, 0);
        arm(); strobe();
        check("R7", vec_addr, 16'h0018);
        ack();
        // R3: a request on the strobe edge itself is not taken yet
        arm();
        irq_req = 12'h010; last_cycle = 1; cyc(); idle();
        check("R3", vec_valid, 0);
        strobe();
        check("R3", vec_addr, 16'h000A);
        ack();
        // R9: a stray acknowledge erases nothing
        irq_req = 12'h002; cyc(); idle();
        ack(); ack();
        arm(); strobe();
        check("R9", vec_addr, 16'h0004);
        ack();
        // Random traffic compared each cycle against the reference
        for (int k = 0; k < 3000; k++) begin
            automatic logic [N-1:0] r = '0;
            for (int b = 0; b < N; b++) r[b] = ($urandom % 12) == 0;
            irq_req = r;
            en_we = ($urandom % 20) == 0; en_wdata = N'($urandom);
            gie_we = ($urandom % 4) == 0; gie_wdata = ($urandom % 3) != 0;
            last_cycle = ($urandom % 3) == 0;
            vec_ack = ($urandom % 3) == 0;
            cyc();
        end
        idle(); cyc(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule